// File: doc/BRIEF.md
# Interrupt Vector Override Page

This block sits in the read and write data path for the top page of bank zero, which holds the main processor's interrupt vectors. On a read it can replace the bytes of the NMI vector (page offsets 0xEA and 0xEB) and of the IRQ vector (page offsets 0xEE and 0xEF) with 16-bit values held in local registers. Each vector has its own enable bit. Every other offset, every read made while the matching enable is clear, and every write are passed between the bus side and the underlying ROM mapping without change.

The read path is purely combinational from the bus inputs and the ROM read data. The register file is written through a small synchronous configuration port. Both processor buses use the same page contents, so one instance can serve whichever bus the surrounding arbiter routes to it. A page-select input qualifies the decode. Only address bits 7:0 reach the block.

Top module: `vec_override_page`

## Requirements
- R1: With control bit 4 set, a read (bus_rd=1, page_sel=1) at offset 0xEA or 0xEB returns a byte of the NMI override value instead of rom_rdata.
- R2: With control bit 6 set, a read at offset 0xEE or 0xEF returns a byte of the IRQ override value instead of rom_rdata.
- R3: The even offset of each pair (0xEA, 0xEE) returns bits 7:0 of the override value, and the odd offset (0xEB, 0xEF) returns bits 15:8.
- R4: When the enable bit for a vector is clear, reads of that vector's two offsets return rom_rdata.
- R5: Reads of any offset other than 0xEA, 0xEB, 0xEE and 0xEF return rom_rdata, whatever the enable bits are set to.
- R6: With page_sel=0 or bus_rd=0, bus_rdata equals rom_rdata for every offset.
- R7: rom_addr, rom_rd, rom_wr and rom_wdata always equal bus_addr, bus_rd, bus_wr and bus_wdata. A bus write never changes the override registers.
- R8: Reset clears the control register and both override values. After reset, setting an enable alone makes its two offsets read 0x00.
- R9: Configuration addresses are 0 for control, 1 and 2 for the NMI value's low and high byte, and 3 and 4 for the IRQ value's low and high byte. A cfg_we write takes effect at the next rising clk edge. Control bits other than 4 and 6 have no effect, and writes to addresses 5 to 7 change nothing.
- R10: The two enables are independent: each one affects only its own vector's offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low synchronous reset |
| page_sel | input | 1 | High when the current access targets the vector page |
| bus_addr | input | 8 | Byte offset within the page |
| bus_rd | input | 1 | Read strobe from the bus |
| bus_wr | input | 1 | Write strobe from the bus |
| bus_wdata | input | 8 | Write data from the bus |
| bus_rdata | output | 8 | Read data returned to the bus |
| rom_addr | output | 8 | Offset forwarded to the underlying mapping |
| rom_rd | output | 1 | Read strobe forwarded to the underlying mapping |
| rom_wr | output | 1 | Write strobe forwarded to the underlying mapping |
| rom_wdata | output | 8 | Write data forwarded to the underlying mapping |
| rom_rdata | input | 8 | Read data from the underlying mapping |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |

## Verification
Read data and the forwarded ROM signals are due in the same cycle as the bus inputs that cause them. The bench therefore drives each access at a falling edge and samples half a period later, before the next rising edge. A configuration write becomes visible only after the rising edge that captures it. The bench checks the old value in the half cycle before that edge and the new value after it, which pins the one-edge latency. Every value the bench expects comes from its own copy of the vector constants and the offset rules, never from the design.

// File: rtl/vop_pkg.sv
package vop_pkg;

  // Widths shared by every module of the block.
  localparam int BYTE_W  = 8;
  localparam int OFS_W   = 8;
  localparam int VEC_W   = 16;
  localparam int CFG_AW  = 3;
  localparam int NSLOT   = 2;

  // Slot 0 is the NMI vector and slot 1 the IRQ vector.
  localparam int SLOT_NMI = 0;
  localparam int SLOT_IRQ = 1;

  // Control register bit positions.
  localparam int NMI_EN_BIT = 4;
  localparam int IRQ_EN_BIT = 6;

  // Even page offset of each vector pair.
  localparam logic [OFS_W-1:0] NMI_BASE = 8'hEA;
  localparam logic [OFS_W-1:0] IRQ_BASE = 8'hEE;

  typedef enum logic [CFG_AW-1:0] {
    CFG_CTRL   = 3'd0,
    CFG_NMI_LO = 3'd1,
    CFG_NMI_HI = 3'd2,
    CFG_IRQ_LO = 3'd3,
    CFG_IRQ_HI = 3'd4
  } cfg_sel_e;

  typedef struct packed {
    logic             nmi_en;
    logic             irq_en;
    logic [VEC_W-1:0] nmi_vec;
    logic [VEC_W-1:0] irq_vec;
  } ovr_cfg_t;

  // True when the offset falls on either byte of the pair that starts at base.
  function automatic logic pair_hit(input logic [OFS_W-1:0] ofs,
                                    input logic [OFS_W-1:0] base);
    return ofs[OFS_W-1:1] == base[OFS_W-1:1];
  endfunction

  // Byte of a vector picked by the low address bit: 0 gives low, 1 gives high.
  function automatic logic [BYTE_W-1:0] vec_byte(input logic [VEC_W-1:0] v,
                                                 input logic             hi);
    return hi ? v[VEC_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/vop_regs.sv
module vop_regs
  import vop_pkg::*;
#(
  parameter int AW = CFG_AW,
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output ovr_cfg_t      cfg_q
);

  ovr_cfg_t cfg_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_r <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_addr))
        CFG_CTRL: begin
          cfg_r.nmi_en <= cfg_wdata[NMI_EN_BIT];
          cfg_r.irq_en <= cfg_wdata[IRQ_EN_BIT];
        end
        CFG_NMI_LO: cfg_r.nmi_vec[DW-1:0]     <= cfg_wdata;
        CFG_NMI_HI: cfg_r.nmi_vec[2*DW-1:DW]  <= cfg_wdata;
        CFG_IRQ_LO: cfg_r.irq_vec[DW-1:0]     <= cfg_wdata;
        CFG_IRQ_HI: cfg_r.irq_vec[2*DW-1:DW]  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  assign cfg_q = cfg_r;

  AST_CTRL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == AW'(CFG_CTRL)) |=>
      (cfg_q.nmi_en == $past(cfg_wdata[NMI_EN_BIT]) &&
       cfg_q.irq_en == $past(cfg_wdata[IRQ_EN_BIT]))); // R9

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we || cfg_addr > AW'(CFG_IRQ_HI)) |=> $stable(cfg_q)); // R7

endmodule

// File: rtl/vop_match.sv
module vop_match
  import vop_pkg::*;
#(
  parameter int OW = OFS_W,
  parameter int NS = NSLOT
) (
  input  logic          page_sel,
  input  logic          bus_rd,
  input  logic [OW-1:0] ofs,
  input  logic [NS-1:0] slot_en,
  output logic [NS-1:0] slot_hit,
  output logic          hi_sel
);

  localparam logic [OW-1:0] SLOT_BASE [NS] = '{NMI_BASE, IRQ_BASE};

  logic rd_active;
  assign rd_active = page_sel && bus_rd;

  for (genvar s = 0; s < NS; s++) begin : g_slot
    assign slot_hit[s] = rd_active && slot_en[s] && pair_hit(ofs, SLOT_BASE[s]);
  end

  assign hi_sel = ofs[0];

endmodule

// File: rtl/vop_mux.sv
module vop_mux
  import vop_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int VW = VEC_W,
  parameter int NS = NSLOT
) (
  input  logic [NS-1:0] slot_hit,
  input  logic          hi_sel,
  input  logic [VW-1:0] slot_vec [NS],
  input  logic [DW-1:0] rom_rdata,
  output logic [DW-1:0] rdata
);

  always_comb begin
    rdata = rom_rdata;
    for (int s = 0; s < NS; s++) begin
      if (slot_hit[s]) rdata = vec_byte(slot_vec[s], hi_sel);
    end
  end

endmodule

// File: rtl/vec_override_page.sv
module vec_override_page
  import vop_pkg::*;
#(
  parameter int OW = OFS_W,
  parameter int DW = BYTE_W,
  parameter int AW = CFG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          page_sel,
  input  logic [OW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [OW-1:0] rom_addr,
  output logic          rom_rd,
  output logic          rom_wr,
  output logic [DW-1:0] rom_wdata,
  input  logic [DW-1:0] rom_rdata,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata
);

  ovr_cfg_t         cfg_q;
  logic [NSLOT-1:0] slot_en;
  logic [NSLOT-1:0] slot_hit;
  logic             hi_sel;
  logic [VEC_W-1:0] slot_vec [NSLOT];

  // Named events for the assertions.
  logic nmi_hit, irq_hit;

  vop_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q)
  );

  assign slot_en[SLOT_NMI]  = cfg_q.nmi_en;
  assign slot_en[SLOT_IRQ]  = cfg_q.irq_en;
  assign slot_vec[SLOT_NMI] = cfg_q.nmi_vec;
  assign slot_vec[SLOT_IRQ] = cfg_q.irq_vec;

  vop_match #(.OW(OW), .NS(NSLOT)) u_match (
    .page_sel (page_sel),
    .bus_rd   (bus_rd),
    .ofs      (bus_addr),
    .slot_en  (slot_en),
    .slot_hit (slot_hit),
    .hi_sel   (hi_sel)
  );

  vop_mux #(.DW(DW), .VW(VEC_W), .NS(NSLOT)) u_mux (
    .slot_hit  (slot_hit),
    .hi_sel    (hi_sel),
    .slot_vec  (slot_vec),
    .rom_rdata (rom_rdata),
    .rdata     (bus_rdata)
  );

  assign nmi_hit = slot_hit[SLOT_NMI];
  assign irq_hit = slot_hit[SLOT_IRQ];

  // Write and strobe path is a straight feed-through.
  assign rom_addr  = bus_addr;
  assign rom_rd    = bus_rd;
  assign rom_wr    = bus_wr;
  assign rom_wdata = bus_wdata;

  AST_NMI_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_hit |-> bus_rdata == (bus_addr[0] ? cfg_q.nmi_vec[15:8]
                                          : cfg_q.nmi_vec[7:0])); // R1

  AST_IRQ_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hit |-> bus_rdata == (bus_addr[0] ? cfg_q.irq_vec[15:8]
                                          : cfg_q.irq_vec[7:0])); // R2

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_sel || !bus_rd) |-> bus_rdata == rom_rdata); // R6

  AST_NMI_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.nmi_en && bus_addr[7:1] == 7'h75) |-> bus_rdata == rom_rdata); // R4

  AST_OTHER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[7:1] != 7'h75 && bus_addr[7:1] != 7'h77) |->
      bus_rdata == rom_rdata); // R5

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nmi_hit, irq_hit})); // R10

endmodule

// File: tb/test_vec_override_page.sv
module test_vec_override_page;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       page_sel;
  logic [7:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] rom_addr;
  logic       rom_rd, rom_wr;
  logic [7:0] rom_wdata, rom_rdata;
  logic       cfg_we;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [15:0] NMI_VAL = 16'hC35A;
  localparam logic [15:0] IRQ_VAL = 16'h917E;

  always #10 clk = ~clk;

  vec_override_page i_vec_override_page (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rom_addr(rom_addr), .rom_rd(rom_rd),
    .rom_wr(rom_wr), .rom_wdata(rom_wdata), .rom_rdata(rom_rdata),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  // Row: sel, rd, offset, rom byte, expected byte, requirement number.
  localparam int NVEC = 12;
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'hEA, 8'h11, 8'h5A, 4'd1}, // R1 R3 low byte
    {1'b1, 1'b1, 8'hEB, 8'h22, 8'hC3, 4'd3}, // R3 high byte
    {1'b1, 1'b1, 8'hEE, 8'h33, 8'h7E, 4'd2}, // R2 low byte
    {1'b1, 1'b1, 8'hEF, 8'h44, 8'h91, 4'd3}, // R3 high byte
    {1'b1, 1'b1, 8'hEC, 8'h55, 8'h55, 4'd5}, // R5
    {1'b1, 1'b1, 8'hE9, 8'h66, 8'h66, 4'd5}, // R5
    {1'b1, 1'b1, 8'hF0, 8'h77, 8'h77, 4'd5}, // R5
    {1'b1, 1'b1, 8'h00, 8'h88, 8'h88, 4'd5}, // R5
    {1'b1, 1'b1, 8'hED, 8'h12, 8'h12, 4'd5}, // R5
    {1'b0, 1'b1, 8'hEA, 8'h99, 8'h99, 4'd6}, // R6 page off
    {1'b0, 1'b1, 8'hEF, 8'hAA, 8'hAA, 4'd6}, // R6 page off
    {1'b1, 1'b0, 8'hEB, 8'hBB, 8'hBB, 4'd6}  // R6 no read
  };

  task automatic check(input logic ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Drive a read at a falling edge; sample half a period later.
  task automatic do_read(input logic sel, input logic [7:0] a,
                         input logic [7:0] rom, input logic [7:0] exp,
                         input string req);
    @(negedge clk);
    page_sel = sel; bus_rd = 1'b1; bus_addr = a; rom_rdata = rom;
    #5;
    check(bus_rdata == exp, req, {8'h00, bus_rdata}, {8'h00, exp});
    bus_rd = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; page_sel = 1'b0; bus_addr = 8'h00; bus_rd = 1'b0;
    bus_wr = 1'b0; bus_wdata = 8'h00; rom_rdata = 8'h00;
    cfg_we = 1'b0; cfg_addr = 3'd0; cfg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset leaves both overrides disabled.
    do_read(1'b1, 8'hEA, 8'h3D, 8'h3D, "R8 reset nmi off");
    do_read(1'b1, 8'hEF, 8'h4E, 8'h4E, "R8 reset irq off");

    // R8: enables set without values give zero bytes.
    cfg_write(3'd0, 8'h50);
    do_read(1'b1, 8'hEA, 8'hFF, 8'h00, "R8 nmi value cleared");
    do_read(1'b1, 8'hEF, 8'hFF, 8'h00, "R8 irq value cleared");

    // Load both vectors (R9 register addresses).
    cfg_write(3'd1, NMI_VAL[7:0]);
    cfg_write(3'd2, NMI_VAL[15:8]);
    cfg_write(3'd3, IRQ_VAL[7:0]);
    cfg_write(3'd4, IRQ_VAL[15:8]);

    for (int i = 0; i < NVEC; i++) begin
      logic [29:0] v;
      v = VEC[i];
      @(negedge clk);
      page_sel = v[29]; bus_rd = v[28]; bus_addr = v[27:20];
      rom_rdata = v[19:12];
      #5;
      check(bus_rdata == v[11:4], $sformatf("R%0d table row %0d", v[3:0], i),
            {8'h00, bus_rdata}, {8'h00, v[11:4]});
      bus_rd = 1'b0;
    end

    // R7: write forwarding and register isolation.
    @(negedge clk);
    page_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'hEA; bus_wdata = 8'h3C;
    #5;
    check(rom_wr && !rom_rd && rom_addr == 8'hEA && rom_wdata == 8'h3C,
          "R7 write forwarded", {rom_addr, rom_wdata}, {8'hEA, 8'h3C});
    @(negedge clk);
    bus_wr = 1'b0;
    do_read(1'b1, 8'hEA, 8'h00, 8'h5A, "R7 vector kept after bus write");
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'hEF;
    #5;
    check(rom_rd && rom_addr == 8'hEF, "R7 read strobe forwarded",
          {7'h0, rom_rd, rom_addr}, {7'h0, 1'b1, 8'hEF});
    bus_rd = 1'b0;

    // R9: writes to 5..7 change nothing.
    cfg_write(3'd5, 8'hFF);
    cfg_write(3'd7, 8'hFF);
    do_read(1'b1, 8'hEB, 8'h00, 8'hC3, "R9 unused address ignored");
    do_read(1'b1, 8'hEF, 8'h00, 8'h91, "R9 unused address ignored irq");

    // R10 and R4: NMI enable only.
    cfg_write(3'd0, 8'h10);
    do_read(1'b1, 8'hEA, 8'h61, 8'h5A, "R10 nmi alone on");
    do_read(1'b1, 8'hEE, 8'h62, 8'h62, "R4 irq off passes rom");
    // IRQ enable only.
    cfg_write(3'd0, 8'h40);
    do_read(1'b1, 8'hEB, 8'h63, 8'h63, "R4 nmi off passes rom");
    do_read(1'b1, 8'hEF, 8'h64, 8'h91, "R10 irq alone on");

    // R9: other control bits have no effect.
    cfg_write(3'd0, 8'hAF);
    do_read(1'b1, 8'hEA, 8'h71, 8'h71, "R9 stray ctrl bits nmi");
    do_read(1'b1, 8'hEE, 8'h72, 8'h72, "R9 stray ctrl bits irq");

    // R9: one-edge latency of a control write.
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'h10;
    page_sel = 1'b1; bus_rd = 1'b1; bus_addr = 8'hEA; rom_rdata = 8'h81;
    #5;
    check(bus_rdata == 8'h81, "R9 before capture edge",
          {8'h00, bus_rdata}, 16'h0081);
    @(negedge clk);
    cfg_we = 1'b0;
    #5;
    check(bus_rdata == 8'h5A, "R9 after capture edge",
          {8'h00, bus_rdata}, 16'h005A);
    bus_rd = 1'b0;

    // R8: reset again clears everything.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_read(1'b1, 8'hEA, 8'h92, 8'h92, "R8 second reset");
    cfg_write(3'd0, 8'h50);
    do_read(1'b1, 8'hEB, 8'h93, 8'h00, "R8 value cleared by reset");

    summary();
  end

endmodule